// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the bit clock and the left/right frame clock of a serial audio port from a fast master clock. It also produces single-cycle strobes in the master clock domain. These strobes let the shift registers of a transmitter or receiver launch and capture data without running logic on the derived clocks. Configuration is static while the port runs: bit-clock divider, frame length, word length, both clock polarities, clock-source select and a gating override.

As clock source, the block counts master cycles into bit periods and bit periods into frames. When a channel half holds more slots than the word length, it holds the bit clock at its idle level through the unused slots. As clock follower, it brings an external bit clock and frame clock through multi-stage synchronizers, finds their edges and produces the same strobes and channel indicator. Its own clock pins then stay idle and undriven.

The clocks run while either the transmit path or the receive path is enabled. Both must be off before the block stops.

Top module: `aud_sclk_gen`

## Requirements
- R1: In source mode (cfg_master=1) one bit period lasts 2 master cycles when cfg_div4=0 and 4 when cfg_div4=1, with the bit clock in its first level for the first half and in the other level for the second half.
- R2: A frame holds 32, 64 or 128 bit slots for cfg_frame_sel 0, 1 or 2, and 128 for value 3. Half the slots are the left channel and half the right. frame_stb pulses once per frame, in the same cycle as the launch strobe of the first left slot.
- R3: With cfg_bclk_inv=0 bclk_o is low in the first half of each bit, so data launches on its falling edge and is sampled on its rising edge. With cfg_bclk_inv=1 the pin is inverted. launch_stb marks the first cycle of a bit and sample_stb marks the middle cycle, and the two never coincide.
- R4: right_ch is 0 during the left half of a frame and 1 during the right half. fclk_o equals right_ch when cfg_fs_inv=0 and its inverse when cfg_fs_inv=1, and it changes only in a launch cycle.
- R5: cfg_word_sel selects a word length of 16, 24 or 32 bits (0, 1, 2; 3 means 32). In source mode, slots whose index within their channel half is at or beyond the word length give no strobes and hold bclk_o at its idle level. cfg_no_gate=1 disables this gating, and no gating occurs when the word fills the half.
- R6: The block runs while tx_en or rx_en is high and stops only once both are low. One cycle after that, bclk_o equals cfg_bclk_inv, fclk_o equals cfg_fs_inv and all strobes are low.
- R7: The counters restart from zero on every enable. In the first cycle after the enable is registered, frame_stb and launch_stb are both high.
- R8: Every strobe is one master cycle wide. In source mode a frame carries exactly one launch strobe and one sample strobe per ungated slot.
- R9: In follower mode (cfg_master=0) the external clocks pass through SYNC_STAGES flops. launch_stb marks each launch edge of ext_bclk (falling when cfg_bclk_inv=0) and sample_stb each other edge. right_ch follows ext_fclk XOR cfg_fs_inv, and frame_stb marks each change of right_ch from 1 to 0. drive_o is 0, and bclk_o and fclk_o stay idle.
- R10: drive_o is 1 exactly while the block runs in source mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | asynchronous active-low reset |
| tx_en | input | 1 | transmit path enable |
| rx_en | input | 1 | receive path enable |
| cfg_master | input | 1 | 1: generate clocks, 0: follow external clocks |
| cfg_div4 | input | 1 | bit period of 4 master cycles instead of 2 |
| cfg_frame_sel | input | 2 | slots per frame: 0=32, 1=64, 2/3=128 |
| cfg_word_sel | input | 2 | word length: 0=16, 1=24, 2/3=32 |
| cfg_bclk_inv | input | 1 | bit-clock polarity |
| cfg_fs_inv | input | 1 | frame-clock polarity |
| cfg_no_gate | input | 1 | keep bit clock running in unused slots |
| ext_bclk | input | 1 | external bit clock (follower mode) |
| ext_fclk | input | 1 | external frame clock (follower mode) |
| bclk_o | output | 1 | generated bit clock |
| fclk_o | output | 1 | generated frame clock |
| drive_o | output | 1 | clock pins are driven by this block |
| launch_stb | output | 1 | data launch point of a bit |
| sample_stb | output | 1 | data sample point of a bit |
| frame_stb | output | 1 | start of a frame (first left slot) |
| right_ch | output | 1 | current slot belongs to the right channel |

## Verification
On every cycle the assertions check the idle state after disable, the one-cycle strobe width, that launch and sample strobes never overlap, that the frame strobe lines up with a left-slot launch, that the frame clock moves only on a launch, that a rising non-inverted bit clock always brings a sample strobe, and that the pins stay quiet in follower mode. Frame length, bit period, the number of ungated slots, the duty of the frame clock and the restart alignment depend on the whole configuration, so only the bench's per-configuration frame measurements show them. The same holds for the strobe counts derived from externally driven clocks.

// File: rtl/aud_sclk_pkg.sv
package aud_sclk_pkg;
   localparam int MAX_SLOTS = 128;
   localparam int MAX_BITDIV = 4;

   function automatic int frame_slots(input logic [1:0] sel);
      case (sel)
         2'd0:    return 32;
         2'd1:    return 64;
         default: return MAX_SLOTS;
      endcase
   endfunction

   function automatic int word_bits(input logic [1:0] sel);
      case (sel)
         2'd0:    return 16;
         2'd1:    return 24;
         default: return 32;
      endcase
   endfunction
endpackage

// File: rtl/aud_sclk_sync.sv
module aud_sclk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic st [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) st[i] <= 1'b0;
               else        st[i] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) st[i] <= 1'b0;
               else        st[i] <= st[i-1];
         end
      end
   endgenerate

   assign q = st[STAGES-1];
endmodule

// File: rtl/aud_sclk_master.sv
module aud_sclk_master #(
   parameter int PC_W   = 2,
   parameter int SLOT_W = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       div4,
   input  logic [1:0] frame_sel,
   input  logic [1:0] word_sel,
   input  logic       no_gate,
   output logic       raw_bclk,
   output logic       raw_right,
   output logic       launch,
   output logic       sample,
   output logic       fstart
);
   logic [PC_W-1:0]   pc_q, pc_last, pc_mid;
   logic [SLOT_W-1:0] sc_q, sc_last, half_mask, in_ch, word_len;
   logic              active;

   always_comb begin
      pc_last   = div4 ? PC_W'(aud_sclk_pkg::MAX_BITDIV - 1) : PC_W'(1);
      pc_mid    = div4 ? PC_W'(aud_sclk_pkg::MAX_BITDIV / 2) : PC_W'(1);
      sc_last   = SLOT_W'(aud_sclk_pkg::frame_slots(frame_sel) - 1);
      half_mask = SLOT_W'(aud_sclk_pkg::frame_slots(frame_sel) / 2 - 1);
      word_len  = SLOT_W'(aud_sclk_pkg::word_bits(word_sel));
      in_ch     = sc_q & half_mask;
      active    = no_gate || (in_ch < word_len);
   end

   // bit period and slot counters, cleared whenever the block is stopped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
         sc_q <= '0;
      end else if (!run) begin
         pc_q <= '0;
         sc_q <= '0;
      end else if (pc_q == pc_last) begin
         pc_q <= '0;
         sc_q <= (sc_q == sc_last) ? '0 : sc_q + 1'b1;
      end else begin
         pc_q <= pc_q + 1'b1;
      end
   end

   assign raw_bclk  = run && active && (pc_q >= pc_mid);
   assign raw_right = run && ((sc_q & ~half_mask) != '0);
   assign launch    = run && active && (pc_q == '0);
   assign sample    = run && active && (pc_q == pc_mid);
   assign fstart    = run && (pc_q == '0) && (sc_q == '0);
endmodule

// File: rtl/aud_sclk_slave.sv
module aud_sclk_slave #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic ext_b,
   input  logic ext_f,
   input  logic b_inv,
   input  logic f_inv,
   output logic launch,
   output logic sample,
   output logic fstart,
   output logic right
);
   logic b_s, f_s, b_prev, f_prev;
   logic b_n, bp_n, f_n, fp_n;

   aud_sclk_sync #(.STAGES(STAGES)) u_sync_b (.clk(clk), .rst_n(rst_n), .d(ext_b), .q(b_s));
   aud_sclk_sync #(.STAGES(STAGES)) u_sync_f (.clk(clk), .rst_n(rst_n), .d(ext_f), .q(f_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_prev <= 1'b0;
         f_prev <= 1'b0;
      end else begin
         b_prev <= b_s;
         f_prev <= f_s;
      end
   end

   always_comb begin
      b_n  = b_s ^ b_inv;
      bp_n = b_prev ^ b_inv;
      f_n  = f_s ^ f_inv;
      fp_n = f_prev ^ f_inv;
   end

   assign launch = run && bp_n && !b_n;
   assign sample = run && !bp_n && b_n;
   assign fstart = run && fp_n && !f_n;
   assign right  = run && f_n;
endmodule

// File: rtl/aud_sclk_gen.sv
module aud_sclk_gen #(
   parameter int SYNC_STAGES = 2,
   parameter int PC_W        = $clog2(aud_sclk_pkg::MAX_BITDIV),
   parameter int SLOT_W      = $clog2(aud_sclk_pkg::MAX_SLOTS)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_en,
   input  logic       rx_en,
   input  logic       cfg_master,
   input  logic       cfg_div4,
   input  logic [1:0] cfg_frame_sel,
   input  logic [1:0] cfg_word_sel,
   input  logic       cfg_bclk_inv,
   input  logic       cfg_fs_inv,
   input  logic       cfg_no_gate,
   input  logic       ext_bclk,
   input  logic       ext_fclk,
   output logic       bclk_o,
   output logic       fclk_o,
   output logic       drive_o,
   output logic       launch_stb,
   output logic       sample_stb,
   output logic       frame_stb,
   output logic       right_ch
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if ((1 << PC_W) < aud_sclk_pkg::MAX_BITDIV) begin : g_bad_pc
         $error("PC_W too narrow for the bit divider");
      end
      if ((1 << SLOT_W) < aud_sclk_pkg::MAX_SLOTS) begin : g_bad_slot
         $error("SLOT_W too narrow for the frame length");
      end
   endgenerate

   logic run_q, m_run, s_run;
   logic m_bclk, m_right, m_launch, m_sample, m_fstart;
   logic s_launch, s_sample, s_fstart, s_right;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= tx_en || rx_en;

   assign m_run = run_q && cfg_master;
   assign s_run = run_q && !cfg_master;

   aud_sclk_master #(.PC_W(PC_W), .SLOT_W(SLOT_W)) u_master (
      .clk(clk), .rst_n(rst_n), .run(m_run), .div4(cfg_div4),
      .frame_sel(cfg_frame_sel), .word_sel(cfg_word_sel), .no_gate(cfg_no_gate),
      .raw_bclk(m_bclk), .raw_right(m_right), .launch(m_launch),
      .sample(m_sample), .fstart(m_fstart));

   aud_sclk_slave #(.STAGES(SYNC_STAGES)) u_slave (
      .clk(clk), .rst_n(rst_n), .run(s_run), .ext_b(ext_bclk), .ext_f(ext_fclk),
      .b_inv(cfg_bclk_inv), .f_inv(cfg_fs_inv), .launch(s_launch),
      .sample(s_sample), .fstart(s_fstart), .right(s_right));

   assign bclk_o     = m_bclk ^ cfg_bclk_inv;
   assign fclk_o     = m_right ^ cfg_fs_inv;
   assign drive_o    = m_run;
   assign launch_stb = m_launch | s_launch;
   assign sample_stb = m_sample | s_sample;
   assign frame_stb  = m_fstart | s_fstart;
   assign right_ch   = cfg_master ? m_right : s_right;
endmodule

// File: rtl/aud_sclk_gen_chk.sv
module aud_sclk_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic rx_en,
   input logic cfg_master,
   input logic cfg_bclk_inv,
   input logic cfg_fs_inv,
   input logic bclk_o,
   input logic fclk_o,
   input logic drive_o,
   input logic launch_stb,
   input logic sample_stb,
   input logic frame_stb,
   input logic right_ch
);
   assert_idle_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_en || rx_en) |=> (bclk_o == cfg_bclk_inv && fclk_o == cfg_fs_inv &&
                             !launch_stb && !sample_stb && !frame_stb));

   assert_launch_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
      launch_stb |=> !launch_stb);

   assert_sample_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> !sample_stb);

   assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(launch_stb && sample_stb));

   assert_rise_samples_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_o && !cfg_bclk_inv && $rose(bclk_o)) |-> sample_stb);

   assert_frame_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && frame_stb) |-> (launch_stb && !right_ch));

   assert_fclk_moves_on_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_o && $past(drive_o) && fclk_o != $past(fclk_o)) |-> launch_stb);

   assert_follower_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_master |-> (!drive_o && bclk_o == cfg_bclk_inv && fclk_o == cfg_fs_inv));

   assert_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && (tx_en || rx_en)) |=> drive_o);
endmodule

bind aud_sclk_gen aud_sclk_gen_chk u_chk (.*);

// File: tb/aud_sclk_gen_bench.sv
module aud_sclk_gen_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 0, rx_en = 0, cfg_master = 1, cfg_div4 = 0;
   logic [1:0] cfg_frame_sel = 0, cfg_word_sel = 0;
   logic cfg_bclk_inv = 0, cfg_fs_inv = 0, cfg_no_gate = 0;
   logic ext_bclk = 0, ext_fclk = 0;
   logic bclk_o, fclk_o, drive_o, launch_stb, sample_stb, frame_stb, right_ch;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   aud_sclk_gen u_aud_sclk_gen (.*);

   // fields: div4, frame_sel, word_sel, bclk_inv, fs_inv, no_gate, period, launches
   localparam logic [25:0] VEC [0:5] = '{
      {1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 10'd64,  8'd32},
      {1'b1, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 10'd256, 8'd32},
      {1'b0, 2'd2, 2'd1, 1'b0, 1'b1, 1'b0, 10'd256, 8'd48},
      {1'b1, 2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 10'd512, 8'd64},
      {1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 10'd128, 8'd64},
      {1'b0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 10'd64,  8'd32}
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_vec(input logic [25:0] v, input int idx);
      int per, lau, d, n, l, s, r, act, mm;
      tx_en = 0; rx_en = 0;
      {cfg_div4, cfg_frame_sel, cfg_word_sel, cfg_bclk_inv, cfg_fs_inv, cfg_no_gate} = v[25:18];
      per = int'(v[17:8]);
      lau = int'(v[7:0]);
      d = cfg_div4 ? 4 : 2;
      repeat (3) @(negedge clk);
      tx_en = 1;
      @(negedge clk);
      chk(frame_stb && launch_stb, $sformatf("R7 vec%0d first-cycle frame", idx), frame_stb, 1);
      chk(bclk_o == cfg_bclk_inv && fclk_o == cfg_fs_inv,
          $sformatf("R3 R4 vec%0d start levels", idx), {bclk_o, fclk_o}, {cfg_bclk_inv, cfg_fs_inv});
      n = 0; l = 0; s = 0; r = 0; act = 0; mm = 0;
      do begin
         l += launch_stb;
         s += sample_stb;
         r += right_ch;
         act += (bclk_o != cfg_bclk_inv);
         mm += (fclk_o != (right_ch ^ cfg_fs_inv));
         @(negedge clk);
         n++;
      end while (!frame_stb && n < 2000);
      chk(n == per, $sformatf("R1 R2 vec%0d frame period", idx), n, per);
      chk(l == lau, $sformatf("R5 vec%0d launches", idx), l, lau);
      chk(s == lau, $sformatf("R8 vec%0d samples", idx), s, lau);
      chk(act == lau * d / 2, $sformatf("R1 R5 vec%0d active bclk cycles", idx), act, lau * d / 2);
      chk(r == per / 2, $sformatf("R2 vec%0d right half", idx), r, per / 2);
      chk(mm == 0, $sformatf("R4 vec%0d fclk polarity", idx), mm, 0);
      tx_en = 0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int l, s, f, bad;
      repeat (3) @(negedge clk);
      chk(bclk_o == 0 && fclk_o == 0 && !drive_o && !launch_stb && !frame_stb,
          "R6 reset state", {bclk_o, fclk_o, drive_o, launch_stb}, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(!drive_o && !launch_stb && !sample_stb, "R6 idle after reset", launch_stb, 0);

      for (int i = 0; i < 6; i++) run_vec(VEC[i], i);

      // enable grouping and idle levels with inverted polarities
      tx_en = 0; rx_en = 0;
      cfg_div4 = 0; cfg_frame_sel = 0; cfg_word_sel = 0; cfg_no_gate = 0;
      cfg_bclk_inv = 1; cfg_fs_inv = 1;
      @(negedge clk); @(negedge clk);
      chk(bclk_o == 1 && fclk_o == 1, "R6 inverted idle levels", {bclk_o, fclk_o}, 3);
      rx_en = 1;
      @(negedge clk);
      chk(frame_stb && launch_stb && drive_o, "R7 R10 start from receive enable", frame_stb, 1);
      tx_en = 1;
      repeat (5) @(negedge clk);
      tx_en = 0;
      l = 0;
      repeat (8) begin @(negedge clk); l += launch_stb; end
      chk(l == 4 && drive_o, "R6 still running with one path on", l, 4);
      rx_en = 0;
      @(negedge clk);
      chk(!drive_o && bclk_o == 1 && fclk_o == 1 && !launch_stb && !sample_stb,
          "R6 stopped after both off", {drive_o, bclk_o, fclk_o}, 3);
      // restart in the middle of a frame
      rx_en = 1;
      repeat (11) @(negedge clk);
      rx_en = 0;
      @(negedge clk);
      rx_en = 1;
      @(negedge clk);
      chk(frame_stb && launch_stb && !right_ch, "R7 restart realigns frame", frame_stb, 1);
      rx_en = 0;
      @(negedge clk);

      // follower mode
      cfg_master = 0; cfg_bclk_inv = 0; cfg_fs_inv = 0;
      ext_bclk = 0; ext_fclk = 0;
      repeat (4) @(negedge clk);
      tx_en = 1;
      repeat (6) @(negedge clk);
      l = 0; s = 0; bad = 0;
      for (int k = 0; k < 10; k++) begin
         ext_bclk = 1;
         repeat (4) begin @(negedge clk); l += launch_stb; s += sample_stb;
                          bad += (drive_o || bclk_o || fclk_o); end
         ext_bclk = 0;
         repeat (4) begin @(negedge clk); l += launch_stb; s += sample_stb;
                          bad += (drive_o || bclk_o || fclk_o); end
      end
      repeat (6) begin @(negedge clk); l += launch_stb; s += sample_stb; end
      chk(l == 10, "R9 follower launches", l, 10);
      chk(s == 10, "R9 follower samples", s, 10);
      chk(bad == 0, "R9 R10 follower pins quiet", bad, 0);
      ext_fclk = 1;
      repeat (6) @(negedge clk);
      chk(right_ch == 1, "R9 follower right channel", right_ch, 1);
      ext_fclk = 0;
      f = 0;
      repeat (6) begin @(negedge clk); f += frame_stb; end
      chk(f == 1 && right_ch == 0, "R9 follower frame start", f, 1);
      // inverted bit clock in follower mode swaps the strobes
      tx_en = 0;
      cfg_bclk_inv = 1;
      @(negedge clk);
      tx_en = 1;
      repeat (4) @(negedge clk);
      ext_bclk = 1;
      l = 0; s = 0;
      repeat (6) begin @(negedge clk); l += launch_stb; s += sample_stb; end
      chk(l == 1 && s == 0, "R9 R3 inverted follower edge", l, 1);
      tx_en = 0;
      @(negedge clk);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule